// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner

This block drives a five-digit multiplexed decimal display, or a host that reads the digits one at a time, from a set of already-latched BCD digits. A single 4-bit bus carries one digit at a time. A group of active-high select lines, one per digit, marks which digit is on the bus. The scan starts at the most significant digit and walks down to the least significant one. It then wraps around and repeats for as long as the result stays valid.

Each new result is announced by a single pulse on `conv_done`. After that pulse the scan restarts at the top digit. During the first pass only, an active-low strobe falls for half a clock period near the middle of each digit slot, which gives five strobes per result. The first slot of every pass is one clock longer than the others.

When the result was out of range, the data bus reads zero for the whole result. All select lines go low after the fifth strobe. They stay low until `ref_phase_start` marks the start of the next reference-integrate phase, and scanning then continues. The effect is a blinking display. A new `conv_done` restarts the scan at once, even in the middle of a pass.

Top module: `bcd_digit_scanner`

## Requirements
- R1: After reset, and until the first `conv_done`, `digit_drv` and `bcd_out` are all zero and `strobe_n` stays high in both clock phases.
- R2: `conv_done` sampled high at a rising edge makes `digit_drv` equal 5'b10000 (bit 4 is the most significant digit) from that edge on. The one-hot selection then steps to bit 3, 2, 1 and 0, and wraps back to bit 4, for as long as no new result arrives.
- R3: The most significant digit slot lasts SLOT_LEN+FIRST_EXTRA = 201 clocks. Every other slot lasts SLOT_LEN = 200 clocks.
- R4: During the first pass after `conv_done`, `strobe_n` is low only in the low phase of the clock. This happens in the clock cycle that begins 101 edges after the `conv_done` edge, and in the cycle that begins 100 edges after each later digit select rises. At all other times `strobe_n` is high.
- R5: Exactly five strobes occur per result, and none occur on later passes, while scanning continues.
- R6: `bcd_out` equals the nibble of the selected digit, and it changes on the same edge as `digit_drv`. The digit selected by `digit_drv[k]` is read from `digits_in[4k+3:4k]`.
- R7: If `over_range` was high when `conv_done` was sampled, `bcd_out` is zero throughout the scan of that result.
- R8: For such an out-of-range result, `digit_drv` is all zero from the edge after the fifth strobe cycle. It stays zero until the edge at which `ref_phase_start` is sampled high. From that edge on, the selection resumes at the position the free-running slot timer has reached.
- R9: A `conv_done` in the middle of a pass restarts the scan at the top digit and produces a fresh set of five strobes at the R4 positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the strobe is also formed from its low phase |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_done | input | 1 | One-cycle pulse: a new result is latched |
| ref_phase_start | input | 1 | One-cycle pulse: the next reference-integrate phase begins |
| over_range | input | 1 | Out-of-range flag for the result, sampled with `conv_done` |
| digits_in | input | 20 | Five latched BCD digits; nibble k belongs to select line k |
| digit_drv | output | 5 | One-hot, active-high digit selects; bit 4 is the most significant digit |
| bcd_out | output | 4 | BCD value of the selected digit, positive-true |
| strobe_n | output | 1 | Active-low half-clock strobe near mid-slot |

## Verification
The embedded assertions check several properties on every clock cycle. The select lines are never more than one-hot. The bus is dark whenever no digit is selected, and it stays dark for a whole out-of-range result. A strobe enable never coincides with a dark display. Blanking only follows an out-of-range result. Every natural slot transition follows a run of exactly 201 or 200 clocks.

The bench scenarios cover what needs a whole result to show. They check the exact strobe positions and the half-clock phase of the strobe. They check that there are five strobes on the first pass and none later. They check the blanking window after the fifth strobe and the resume point set by `ref_phase_start`, and the clean restart when a result arrives mid-pass.

// File: rtl/scan_pkg.sv
// Package for the digit scanner.
// Holds the slot-length and strobe-position arithmetic shared by the timer
// and its checks. Assumes the first slot of a pass is the stretched one.
package scan_pkg;

    // Last counter value of a slot (slot length minus one).
    function automatic int slot_last(input bit first_slot, input int len, input int extra);
        return first_slot ? (len + extra - 1) : (len - 1);
    endfunction

    // Counter value inside a slot at which the strobe enable is raised.
    function automatic int strobe_point(input bit first_slot, input int at, input int extra);
        return first_slot ? (at + extra) : at;
    endfunction

endpackage

// File: rtl/scan_timer.sv
// Slot timer for the digit scanner.
// Counts clocks inside each digit slot, steps the slot index from the most
// significant digit down, limits strobes to the first pass, and holds the
// out-of-range blanking flag. It exposes its next-state values so the
// output registers load on the same edge as the timer. Assumes conv_done
// and ref_phase_start are synchronous single-cycle pulses.
module scan_timer
    import scan_pkg::*;
#(
    parameter int N_DIGITS    = 5,
    parameter int SLOT_LEN    = 200,
    parameter int FIRST_EXTRA = 1,
    parameter int STROBE_AT   = 100,
    localparam int CNT_W      = $clog2(SLOT_LEN + FIRST_EXTRA + 1),
    localparam int IDX_W      = (N_DIGITS > 1) ? $clog2(N_DIGITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_done,
    input  logic             ref_phase_start,
    input  logic             over_range,
    output logic             nxt_active,
    output logic [IDX_W-1:0] nxt_idx,
    output logic             nxt_blank,
    output logic             nxt_or,
    output logic             strb_en,
    output logic             or_flag
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_DIGITS - 1);
    localparam logic [CNT_W-1:0] LIM_FIRST = CNT_W'(slot_last(1'b1, SLOT_LEN, FIRST_EXTRA));
    localparam logic [CNT_W-1:0] LIM_REST  = CNT_W'(slot_last(1'b0, SLOT_LEN, FIRST_EXTRA));
    localparam logic [CNT_W-1:0] PT_FIRST  = CNT_W'(strobe_point(1'b1, STROBE_AT, FIRST_EXTRA));
    localparam logic [CNT_W-1:0] PT_REST   = CNT_W'(strobe_point(1'b0, STROBE_AT, FIRST_EXTRA));

    logic             act_q, first_q, blank_q, or_q, strb_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             act_n, first_n, blank_n, or_n, strb_n;
    logic [IDX_W-1:0] idx_n;
    logic [CNT_W-1:0] cnt_n;
    logic [CNT_W-1:0] lim;

    // Slot length limit for the current slot.
    assign lim = (idx_q == '0) ? LIM_FIRST : LIM_REST;

    // Next-state logic: restart, slot stepping, blanking and strobe slot.
    always_comb begin
        act_n   = act_q;
        idx_n   = idx_q;
        cnt_n   = cnt_q;
        first_n = first_q;
        blank_n = blank_q;
        or_n    = or_q;
        if (conv_done) begin
            act_n   = 1'b1;
            idx_n   = '0;
            cnt_n   = '0;
            first_n = 1'b1;
            blank_n = 1'b0;
            or_n    = over_range;
        end else begin
            if (act_q) begin
                if (cnt_q == lim) begin
                    cnt_n = '0;
                    if (idx_q == LAST_IDX) begin
                        idx_n   = '0;
                        first_n = 1'b0;
                    end else begin
                        idx_n = idx_q + 1'b1;
                    end
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            if (ref_phase_start) begin
                blank_n = 1'b0;
            end else if (strb_q && idx_q == LAST_IDX && or_q) begin
                blank_n = 1'b1;
            end
        end
        strb_n = act_n && first_n &&
                 (cnt_n == ((idx_n == '0) ? PT_FIRST : PT_REST));
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            idx_q   <= '0;
            cnt_q   <= '0;
            first_q <= 1'b0;
            blank_q <= 1'b0;
            or_q    <= 1'b0;
            strb_q  <= 1'b0;
        end else begin
            act_q   <= act_n;
            idx_q   <= idx_n;
            cnt_q   <= cnt_n;
            first_q <= first_n;
            blank_q <= blank_n;
            or_q    <= or_n;
            strb_q  <= strb_n;
        end
    end

    assign nxt_active = act_n;
    assign nxt_idx    = idx_n;
    assign nxt_blank  = blank_n;
    assign nxt_or     = or_n;
    assign strb_en    = strb_q;
    assign or_flag    = or_q;

    // R8: blanking is only ever raised for an out-of-range result.
    a_r8_blank_needs_or: assert property (@(posedge clk) disable iff (!rst_n)
        blank_q |-> or_q);

    // R4: the strobe enable lasts exactly one clock cycle.
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        strb_q |=> !strb_q);

endmodule

// File: rtl/digit_mux.sv
// Output stage of the digit scanner.
// Registers the one-hot digit selects and the BCD bus from the timer's
// next-state values, so both change on the same edge. Select bit k carries
// nibble k of digits_in. Assumes digits_in is held stable by its owner.
module digit_mux #(
    parameter int N_DIGITS = 5,
    localparam int IDX_W   = (N_DIGITS > 1) ? $clog2(N_DIGITS) : 1,
    localparam int BUS_W   = 4 * N_DIGITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                nxt_active,
    input  logic [IDX_W-1:0]    nxt_idx,
    input  logic                nxt_blank,
    input  logic                nxt_or,
    input  logic [BUS_W-1:0]    digits_in,
    output logic [N_DIGITS-1:0] digit_drv,
    output logic [3:0]          bcd_out
);
    logic [N_DIGITS-1:0] sel;
    logic [3:0]          bcd_d;

    // Select decode: slot index 0 maps to the top select line.
    for (genvar g = 0; g < N_DIGITS; g++) begin : g_sel
        assign sel[g] = nxt_active && !nxt_blank &&
                        (nxt_idx == IDX_W'(N_DIGITS - 1 - g));
    end

    // AND-OR bus mux, forced to zero for an out-of-range result.
    always_comb begin
        bcd_d = '0;
        for (int i = 0; i < N_DIGITS; i++) begin
            if (sel[i]) bcd_d = bcd_d | digits_in[4*i +: 4];
        end
        if (nxt_or) bcd_d = '0;
    end

    // Output registers for selects and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digit_drv <= '0;
            bcd_out   <= '0;
        end else begin
            digit_drv <= sel;
            bcd_out   <= bcd_d;
        end
    end

    // R6: a dark display never carries data on the bus.
    a_r6_dark_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_drv == '0) |-> (bcd_out == '0));

endmodule

// File: rtl/strobe_gen.sv
// Half-clock strobe former.
// Drives the active-low strobe during the low phase of the clock in the
// cycle where the registered enable is high. Assumes the enable changes
// only on rising edges, so the output cannot glitch in the low phase.
module strobe_gen (
    input  logic clk,
    input  logic strb_en,
    output logic strobe_n
);
    // Gate the enable with the low clock phase.
    assign strobe_n = ~(strb_en & ~clk);
endmodule

// File: rtl/bcd_digit_scanner.sv
// Top of the multiplexed BCD digit scanner.
// Scans latched digits onto a shared 4-bit bus with one-hot selects, the
// first slot stretched by FIRST_EXTRA clocks. It issues one half-clock
// strobe per slot on the first pass after each result, and blanks the
// display after the last strobe of an out-of-range result until the next
// reference phase starts. Assumes the inputs are synchronous to clk.
module bcd_digit_scanner #(
    parameter int N_DIGITS    = 5,
    parameter int SLOT_LEN    = 200,
    parameter int FIRST_EXTRA = 1,
    parameter int STROBE_AT   = 100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    conv_done,
    input  logic                    ref_phase_start,
    input  logic                    over_range,
    input  logic [4*N_DIGITS-1:0]   digits_in,
    output logic [N_DIGITS-1:0]     digit_drv,
    output logic [3:0]              bcd_out,
    output logic                    strobe_n
);
    localparam int IDX_W = (N_DIGITS > 1) ? $clog2(N_DIGITS) : 1;
    localparam int RUN_W = 16;
    localparam logic [N_DIGITS-1:0] TOP_SEL = N_DIGITS'(1) << (N_DIGITS - 1);

    logic             nxt_active, nxt_blank, nxt_or, strb_en, or_flag;
    logic [IDX_W-1:0] nxt_idx;

    scan_timer #(
        .N_DIGITS(N_DIGITS), .SLOT_LEN(SLOT_LEN),
        .FIRST_EXTRA(FIRST_EXTRA), .STROBE_AT(STROBE_AT)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done),
        .ref_phase_start(ref_phase_start), .over_range(over_range),
        .nxt_active(nxt_active), .nxt_idx(nxt_idx), .nxt_blank(nxt_blank),
        .nxt_or(nxt_or), .strb_en(strb_en), .or_flag(or_flag)
    );

    digit_mux #(.N_DIGITS(N_DIGITS)) u_mux (
        .clk(clk), .rst_n(rst_n), .nxt_active(nxt_active), .nxt_idx(nxt_idx),
        .nxt_blank(nxt_blank), .nxt_or(nxt_or), .digits_in(digits_in),
        .digit_drv(digit_drv), .bcd_out(bcd_out)
    );

    strobe_gen u_strobe (.clk(clk), .strb_en(strb_en), .strobe_n(strobe_n));

    // Slot-width observer: length of each run of an unchanged select value.
    logic [N_DIGITS-1:0] drv_prev;
    logic [RUN_W-1:0]    run_len;
    logic                run_ok, done_q;

    // Track the previous select value and the length of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_prev <= '0;
            run_len  <= '0;
            run_ok   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            drv_prev <= digit_drv;
            done_q   <= conv_done;
            if (done_q || digit_drv != drv_prev) begin
                run_len <= RUN_W'(1);
                run_ok  <= done_q || (drv_prev != '0);
            end else if (run_len != '1) begin
                run_len <= run_len + 1'b1;
            end
        end
    end

    // R2: at most one digit is selected at any time.
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(digit_drv));

    // R3: the top-digit slot runs SLOT_LEN+FIRST_EXTRA clocks.
    a_r3_first_slot_len: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && !done_q && drv_prev == TOP_SEL && digit_drv == (TOP_SEL >> 1))
        |-> (run_len == RUN_W'(SLOT_LEN + FIRST_EXTRA)));

    // R3: every other slot runs SLOT_LEN clocks.
    a_r3_other_slot_len: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && !done_q && drv_prev != '0 && drv_prev != TOP_SEL &&
         digit_drv != '0 && digit_drv != drv_prev)
        |-> (run_len == RUN_W'(SLOT_LEN)));

    // R4: a strobe slot always falls while a digit is displayed.
    a_r4_strobe_lit: assert property (@(posedge clk) disable iff (!rst_n)
        strb_en |-> (digit_drv != '0));

    // R7: an out-of-range result keeps the bus at zero.
    a_r7_or_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        or_flag |-> (bcd_out == 4'h0));

endmodule

// File: tb/test_bcd_digit_scanner.sv
module test_bcd_digit_scanner;
    localparam int N    = 5;
    localparam int L    = 200;
    localparam int EX   = 1;
    localparam int SAT  = 100;
    localparam int PASS = L + EX + (N - 1) * L;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           conv_done = 1'b0;
    logic           ref_phase_start = 1'b0;
    logic           over_range = 1'b0;
    logic [4*N-1:0] digits_in = '0;
    logic [N-1:0]   digit_drv;
    logic [3:0]     bcd_out;
    logic           strobe_n;

    int n_tests = 0;
    int n_fail  = 0;
    int strobes_seen;

    always #5 clk = ~clk;

    bcd_digit_scanner i_bcd_digit_scanner (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done),
        .ref_phase_start(ref_phase_start), .over_range(over_range),
        .digits_in(digits_in), .digit_drv(digit_drv), .bcd_out(bcd_out),
        .strobe_n(strobe_n)
    );

    task automatic check(input string tag, input int act, input int exp, input int k);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, k, act, exp);
        end
    endtask

    // Run ncyc cycles after a conv_done already set up; integ_at < 0 means no ref phase pulse.
    task automatic run_scan(input int ncyc, input logic [4*N-1:0] dg, input bit ovr,
                            input int integ_at, input string pre);
        strobes_seen = 0;
        for (int k = 0; k < ncyc; k++) begin
            int p, idx, cnt, exp_drv, exp_bcd, exp_low;
            bit blank;
            string tg;
            @(posedge clk);
            #2;
            conv_done = 1'b0;
            ref_phase_start = (integ_at >= 0 && k == integ_at - 1);
            p   = k % PASS;
            idx = (p < L + EX) ? 0 : 1 + (p - L - EX) / L;
            cnt = (p < L + EX) ? p : (p - L - EX) % L;
            blank = ovr && (k >= PASS - L + SAT + 1) && (integ_at < 0 || k < integ_at);
            exp_drv = blank ? 0 : (1 << (N - 1 - idx));
            exp_bcd = (blank || ovr) ? 0 : int'(dg[4*(N-1-idx) +: 4]);
            exp_low = (k < PASS && cnt == ((idx == 0) ? SAT + EX : SAT)) ? 1 : 0;
            if (ovr && k >= PASS - L + SAT + 1) tg = "R8";
            else if (idx == 1 && cnt == 0) tg = "R3";
            else tg = "R2";
            check({pre, tg, " drive"}, int'(digit_drv), exp_drv, k);
            check({pre, ovr ? "R7" : "R6", " bcd"}, int'(bcd_out), exp_bcd, k);
            check({pre, "R4 strobe high phase"}, int'(strobe_n), 1, k);
            #5;
            if (!strobe_n) strobes_seen++;
            check({pre, (k < PASS) ? "R4" : "R5", " strobe low phase"},
                  int'(strobe_n), exp_low ? 0 : 1, k);
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [4*N-1:0] pats [3];
        pats[0] = 20'h13579;
        pats[1] = 20'h86420;
        pats[2] = 20'h90201;

        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R1: idle after reset
        for (int i = 0; i < 20; i++) begin
            @(posedge clk);
            #2;
            digits_in = 20'h55555;
            check("R1 drive", int'(digit_drv), 0, i);
            check("R1 bcd", int'(bcd_out), 0, i);
            #5;
            check("R1 strobe", int'(strobe_n), 1, i);
        end

        // R2..R6: normal results, two passes each, several digit patterns
        for (int s = 0; s < 3; s++) begin
            digits_in  = pats[s];
            over_range = 1'b0;
            conv_done  = 1'b1;
            run_scan(2 * PASS + 5, pats[s], 1'b0, -1, "");
            check("R5 strobe count", strobes_seen, 5, s);
        end

        // R7, R8: out-of-range result, blanking then resume on ref phase
        digits_in  = 20'h77777;
        over_range = 1'b1;
        conv_done  = 1'b1;
        run_scan(PASS + 300, 20'h77777, 1'b1, PASS + 150, "");
        check("R5 strobe count overrange", strobes_seen, 5, 0);
        over_range = 1'b0;

        // R9: restart in the middle of a pass
        digits_in = 20'h24681;
        conv_done = 1'b1;
        run_scan(450, 20'h24681, 1'b0, -1, "R9/");
        digits_in = 20'h97531;
        conv_done = 1'b1;
        run_scan(PASS + 10, 20'h97531, 1'b0, -1, "R9/");
        check("R9 fresh strobe count", strobes_seen, 5, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule